// File: doc/BRIEF.md
# Half-Group Access Merger

This block receives one memory access request from a group of sixteen lanes and decides whether the whole group can be served by a single contiguous, naturally aligned memory transaction. Each lane supplies an enable bit and a byte address. All lanes share one element size of 4, 8 or 16 bytes. When the lanes qualify, the block issues one segment-sized transaction that covers every enabled lane. When they do not, it falls back to one element-sized transaction per enabled lane.

Requests arrive on a valid/ready handshake. Transactions leave on a second valid/ready handshake. Each transaction carries a start address, a byte count, a lane mask and a flag that says whether it is a merged segment. The block holds a single request at a time. A new request is taken only after the last transaction of the previous one has left.

Top module: `coal_unit`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `txn_valid` is 0.
- R2: The size code gives the element size and the segment size (sixteen elements): code 0 is 4 bytes with a 64-byte segment, code 1 is 8 bytes with 128, code 2 is 16 bytes with 256, and code 3 acts exactly like code 2.
- R3: The anchor is the address of the lowest-numbered enabled lane minus that lane's index times the element size. A request merges when the anchor is a multiple of the segment size and every enabled lane k addresses anchor + k * element size. A merged request produces exactly one transaction with address = anchor, byte count = segment size, mask = the enable vector (bit k is lane k) and `txn_coalesced` = 1.
- R4: Disabled lanes never prevent a merge: an enable vector with holes, or with a single enabled lane, merges whenever the enabled lanes satisfy R3.
- R5: A request that does not merge produces one transaction per enabled lane, in ascending lane order. Each has that lane's address, byte count = element size, mask = only bit k set, and `txn_coalesced` = 0.
- R6: While `txn_valid` is 1 and `txn_ready` is 0, all transaction outputs hold their values. The block moves to the next transaction only on a handshake.
- R7: A request with no enabled lanes is accepted, produces no transaction, and `req_ready` is 1 again in the next cycle.
- R8: For a request with at least one enabled lane, the first transaction is valid in the cycle after acceptance. `req_ready` stays 0 until the cycle after the handshake of that request's last transaction, and `req_ready` and `txn_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_active | input | LANES | Lane enable, bit k for lane k |
| req_addr | input | LANES*AW | Lane byte addresses, lane k at bits k*AW +: AW |
| req_size | input | 2 | Element size code (R2) |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | AW | Transaction start byte address |
| txn_bytes | output | BYTES_W | Transaction length in bytes |
| txn_mask | output | LANES | Lanes served by the transaction |
| txn_coalesced | output | 1 | 1 for a merged segment transaction |

## Verification
The request is registered on the accepting edge, so the bench checks the first transaction at the falling edge that follows it. After each handshake edge, the next transaction, or a raised `req_ready`, is due one edge later. Checks run at falling edges, so every registered result has settled by then. Back-pressure is drawn at random each cycle, which shows whether a stalled transaction holds its value across the stall and is still taken in order. The expected transaction list for each request is built ahead of time by a bench model of the merge rules, and outputs are compared entry by entry.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MERGE = 2'd1,
        ST_SPLIT = 2'd2
    } coal_state_e;

    // verdict of the merge test for one request
    typedef struct packed {
        logic any;    // at least one lane enabled
        logic merge;  // request fits one aligned segment
    } coal_verdict_t;

    // log2 of the element size in bytes for a size code
    function automatic logic [2:0] elem_shift(input logic [1:0] code);
        case (code)
            2'd0:    elem_shift = 3'd2;
            2'd1:    elem_shift = 3'd3;
            default: elem_shift = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/coal_lowest.sv
module coal_lowest #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign onehot = req & (~req + N'(1));
    assign found  = |req;
endmodule

// File: rtl/coal_eval.sv
module coal_eval
    import coal_pkg::*;
#(
    parameter int LANES = 16,
    parameter int AW    = 32,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES-1:0]    active,
    input  logic [LANES*AW-1:0] addr,
    input  logic [1:0]          size_code,
    output coal_verdict_t       verdict,
    output logic [AW-1:0]       anchor
);
    logic [LW-1:0]    lead_idx;
    logic [LANES-1:0] lead_onehot;
    logic             any;
    logic [2:0]       esh;
    logic [7:0]       seg_sh;
    logic [AW-1:0]    seg_low;
    logic [AW-1:0]    lead_addr;
    logic [LANES-1:0] lane_ok;

    coal_lowest #(.N(LANES)) u_lead (
        .req    (active),
        .onehot (lead_onehot),
        .idx    (lead_idx),
        .found  (any)
    );

    assign esh       = elem_shift(size_code);
    assign seg_sh    = 8'(esh) + 8'(LW);
    assign seg_low   = ~({AW{1'b1}} << seg_sh);
    assign lead_addr = addr[lead_idx*AW +: AW];
    assign anchor    = lead_addr - (AW'(lead_idx) << esh);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ok[k] = !active[k] ||
                            (addr[k*AW +: AW] == anchor + (AW'(k) << esh));
    end

    assign verdict.any   = any;
    assign verdict.merge = any && ((anchor & seg_low) == '0) && (&lane_ok);
endmodule

// File: rtl/coal_issue.sv
module coal_issue
    import coal_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int AW      = 32,
    parameter int BYTES_W = 9,
    localparam int LW     = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [1:0]          req_size,
    input  coal_verdict_t       verdict,
    input  logic [AW-1:0]       anchor,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_addr,
    output logic [BYTES_W-1:0]  txn_bytes,
    output logic [LANES-1:0]    txn_mask,
    output logic                txn_coalesced
);
    coal_state_e         state;
    logic [LANES-1:0]    pend;
    logic [LANES*AW-1:0] addr_q;
    logic [1:0]          code_q;
    logic [AW-1:0]       anchor_q;

    logic [LANES-1:0]    pick_oh;
    logic [LW-1:0]       pick_idx;
    logic                pick_any;
    logic [LANES-1:0]    pend_next;
    logic [BYTES_W-1:0]  elem_b;
    logic                accept;
    logic                fire;

    coal_lowest #(.N(LANES)) u_pick (
        .req    (pend),
        .onehot (pick_oh),
        .idx    (pick_idx),
        .found  (pick_any)
    );

    assign accept    = req_valid && req_ready;
    assign fire      = txn_valid && txn_ready;
    assign pend_next = pend & ~pick_oh;
    assign elem_b    = BYTES_W'(1) << elem_shift(code_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend     <= '0;
            addr_q   <= '0;
            code_q   <= '0;
            anchor_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && verdict.any) begin
                        state    <= verdict.merge ? ST_MERGE : ST_SPLIT;
                        pend     <= req_active;
                        addr_q   <= req_addr;
                        code_q   <= req_size;
                        anchor_q <= anchor;
                    end
                end
                ST_MERGE: begin
                    if (fire) begin
                        state <= ST_IDLE;
                        pend  <= '0;
                    end
                end
                ST_SPLIT: begin
                    if (fire) begin
                        pend <= pend_next;
                        if (pend_next == '0) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state == ST_IDLE);
        txn_valid     = 1'b0;
        txn_addr      = '0;
        txn_bytes     = '0;
        txn_mask      = '0;
        txn_coalesced = 1'b0;
        if (state == ST_MERGE) begin
            txn_valid     = 1'b1;
            txn_addr      = anchor_q;
            txn_bytes     = elem_b << LW;
            txn_mask      = pend;
            txn_coalesced = 1'b1;
        end else if (state == ST_SPLIT) begin
            txn_valid = pick_any;
            txn_addr  = addr_q[pick_idx*AW +: AW];
            txn_bytes = elem_b;
            txn_mask  = pick_oh;
        end
    end
endmodule

// File: rtl/coal_unit.sv
module coal_unit
    import coal_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int AW      = 32,
    localparam int BYTES_W = $clog2(16 * LANES) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [LANES-1:0]    req_active,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [1:0]          req_size,
    output logic                txn_valid,
    input  logic                txn_ready,
    output logic [AW-1:0]       txn_addr,
    output logic [BYTES_W-1:0]  txn_bytes,
    output logic [LANES-1:0]    txn_mask,
    output logic                txn_coalesced
);
    coal_verdict_t verdict;
    logic [AW-1:0] anchor;

    coal_eval #(.LANES(LANES), .AW(AW)) u_eval (
        .active    (req_active),
        .addr      (req_addr),
        .size_code (req_size),
        .verdict   (verdict),
        .anchor    (anchor)
    );

    coal_issue #(.LANES(LANES), .AW(AW), .BYTES_W(BYTES_W)) u_issue (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_active    (req_active),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .verdict       (verdict),
        .anchor        (anchor),
        .txn_valid     (txn_valid),
        .txn_ready     (txn_ready),
        .txn_addr      (txn_addr),
        .txn_bytes     (txn_bytes),
        .txn_mask      (txn_mask),
        .txn_coalesced (txn_coalesced)
    );
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES   = 16,
    parameter int AW      = 32,
    parameter int BYTES_W = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LANES-1:0]   req_active,
    input logic               txn_valid,
    input logic               txn_ready,
    input logic [AW-1:0]      txn_addr,
    input logic [BYTES_W-1:0] txn_bytes,
    input logic [LANES-1:0]   txn_mask,
    input logic               txn_coalesced
);
    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (req_ready && !txn_valid));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) &&
            $stable(txn_bytes) && $stable(txn_mask) && $stable(txn_coalesced)));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && txn_valid));

    assert_start_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (|req_active)) |=> txn_valid);

    assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !(|req_active)) |=> req_ready);

    assert_merge_align_R3: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && txn_coalesced) |->
            ((txn_addr & (AW'(txn_bytes) - AW'(1))) == '0));

    assert_split_single_R5: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_coalesced) |-> ($countones(txn_mask) == 1));
endmodule

bind coal_unit coal_checker #(.LANES(LANES), .AW(AW), .BYTES_W(BYTES_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_active    (req_active),
    .txn_valid     (txn_valid),
    .txn_ready     (txn_ready),
    .txn_addr      (txn_addr),
    .txn_bytes     (txn_bytes),
    .txn_mask      (txn_mask),
    .txn_coalesced (txn_coalesced)
);

// File: tb/sim_coal_unit.sv
module sim_coal_unit;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 16;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [L-1:0]  req_active = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [AW-1:0] txn_addr;
    logic [8:0]    txn_bytes;
    logic [L-1:0]  txn_mask;
    logic          txn_coalesced;

    always #(CLK_PERIOD / 2) clk = ~clk;

    coal_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_bytes(txn_bytes), .txn_mask(txn_mask), .txn_coalesced(txn_coalesced)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] la [L];
    logic [31:0] e_addr [L];
    logic [8:0]  e_bytes [L];
    logic [15:0] e_mask [L];
    bit          e_coal [L];
    int          e_n;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    function automatic int esize(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : 16;   // R2 size codes
    endfunction

    // bench model of the merge rules (R3, R4, R5)
    task automatic build_expect(input logic [15:0] act, input logic [1:0] c);
        int es, lead;
        logic [31:0] base;
        bit ok;
        es = esize(c);
        e_n = 0;
        if (act == 0) return;
        lead = 0;
        for (int k = L - 1; k >= 0; k--) if (act[k]) lead = k;
        base = la[lead] - 32'(lead * es);
        ok = (base % (16 * es)) == 0;
        for (int k = 0; k < L; k++)
            if (act[k] && la[k] != base + 32'(k * es)) ok = 0;
        if (ok) begin
            e_addr[0] = base; e_bytes[0] = 9'(16 * es); e_mask[0] = act; e_coal[0] = 1;
            e_n = 1;
        end else begin
            for (int k = 0; k < L; k++) if (act[k]) begin
                e_addr[e_n] = la[k]; e_bytes[e_n] = 9'(es);
                e_mask[e_n] = 16'(1) << k; e_coal[e_n] = 0;
                e_n++;
            end
        end
    endtask

    task automatic run_req(input logic [15:0] act, input logic [1:0] c, input string tag);
        int idx;
        bit stalled;
        string t;
        build_expect(act, c);
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready before request", req_ready, 1);
        req_valid = 1'b1; req_active = act; req_size = c;
        for (int k = 0; k < L; k++) req_addr[k*AW +: AW] = la[k];
        @(negedge clk);
        req_valid = 1'b0;
        if (e_n == 0) begin
            check(req_ready == 1'b1, "R7 empty ready", req_ready, 1);
            check(txn_valid == 1'b0, "R7 empty no txn", txn_valid, 0);
            return;
        end
        idx = 0;
        stalled = 0;
        while (idx < e_n) begin
            t = stalled ? "R6" : (e_coal[idx] ? tag : "R5");
            check(txn_valid == 1'b1, {t, " valid"}, txn_valid, 1);
            check(txn_addr == e_addr[idx], {t, " addr"}, txn_addr, e_addr[idx]);
            check(txn_bytes == e_bytes[idx], {t, " bytes"}, txn_bytes, e_bytes[idx]);
            check(txn_mask == e_mask[idx], {t, " mask"}, txn_mask, e_mask[idx]);
            check(txn_coalesced == e_coal[idx], {t, " merged flag"}, txn_coalesced, e_coal[idx]);
            check(req_ready == 1'b0, "R8 busy", req_ready, 0);
            txn_ready = ($urandom % 4) != 0;
            @(posedge clk);
            stalled = !txn_ready;
            if (txn_ready) idx++;
            @(negedge clk);
        end
        txn_ready = 1'b0;
        check(txn_valid == 1'b0, "R8 drained", txn_valid, 0);
        check(req_ready == 1'b1, "R8 ready after last", req_ready, 1);
    endtask

    task automatic fill_linear(input logic [31:0] base, input logic [1:0] c);
        for (int k = 0; k < L; k++) la[k] = base + 32'(k * esize(c));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] tmp;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(txn_valid == 1'b0, "R1 valid", txn_valid, 0);

        fill_linear(32'h0000_1000, 2'd0);
        run_req(16'hFFFF, 2'd0, "R3");              // full aligned merge
        fill_linear(32'h0000_2080, 2'd1);
        run_req(16'h0F0A, 2'd1, "R4");              // holes still merge
        fill_linear(32'h0000_3000, 2'd1);
        run_req(16'h0200, 2'd1, "R4");              // single lane 9 merges
        fill_linear(32'h0000_3000, 2'd0);
        tmp = la[2]; la[2] = la[5]; la[5] = tmp;
        run_req(16'hFFFF, 2'd0, "R3");              // swapped lanes: split, R5
        fill_linear(32'h0000_4010, 2'd2);
        run_req(16'h00FF, 2'd2, "R3");              // misaligned anchor: split
        run_req(16'h0000, 2'd0, "R7");              // no lanes
        fill_linear(32'h0000_5100, 2'd3);
        run_req(16'hFFFF, 2'd3, "R2");              // code 3 as 16 bytes, 256 segment
        fill_linear(32'h0000_6100, 2'd2);
        run_req(16'hFFF0, 2'd2, "R2");              // code 2 segment

        for (int i = 0; i < 300; i++) begin
            logic [1:0] c;
            logic [15:0] act;
            int kind;
            c = 2'($urandom % 4);
            act = ($urandom % 16 == 0) ? 16'h0 : 16'($urandom);
            kind = $urandom % 4;
            fill_linear(($urandom & 32'hFFFF_F000) + ((kind == 2) ? 32'(esize(c)) : 32'h0), c);
            if (kind == 1) begin
                int a, b;
                a = $urandom % L; b = $urandom % L;
                tmp = la[a]; la[a] = la[b]; la[b] = tmp;
            end else if (kind == 3) begin
                for (int k = 0; k < L; k++) la[k] = $urandom;
            end
            run_req(act, c, "R3");
        end
        finish_run();
    end
endmodule